// File: doc/BRIEF.md
# Periodic CPU Pause Generator

This block derives a processor clock from the board oscillator and, on a fixed repeating schedule, stops the processor for a long window. It exists to test whether a processor and its surrounding logic survive being paused. A free-running binary divider counts oscillator cycles. One low-order divider bit provides the processor clock. The most significant bit marks the pause window, which covers the upper half of every divider period.

The pause is applied in one of two ways, chosen by a mode input. In stretch mode, the processor clock is held high for as long as the window lasts, so the processor is frozen in its high phase. In ready mode, the processor clock keeps running. A ready line, registered on each rising edge of the processor clock, is driven low for the window instead. A pause-active output follows the window in both modes, so that a logic analyser can trigger on it.

Top module: `cpu_pause_gen`

## Requirements
- R1: A synchronous reset, active high, clears the divider to zero. In the cycle after a reset edge, cpu_clk_o is 0, halt_o is 0 and ready_o is 1.
- R2: The divider is 10 bits wide and advances by one on every oscillator edge, wrapping from 1023 to 0. halt_o first rises 512 oscillator cycles after reset is released, and it is high for exactly 512 cycles in every 1024.
- R3: In ready mode (mode_i = 1), cpu_clk_o always equals divider bit 3. The processor clock therefore has a period of 16 oscillator cycles and keeps toggling through the pause window.
- R4: In stretch mode (mode_i = 0), cpu_clk_o equals divider bit 3 while divider bit 9 is clear, and it is held at 1 while bit 9 is set.
- R5: In ready mode, ready_o changes only on the oscillator edge at which cpu_clk_o goes from 0 to 1.
- R6: At each rising edge of the processor clock in ready mode, ready_o is loaded with the inverse of divider bit 9 as it stands after that edge. As a result, ready_o goes low at divider count 520 and returns high at count 8 of the next period.
- R7: One cycle after any edge at which mode_i is 0 (stretch mode), ready_o is 1.
- R8: halt_o equals divider bit 9 in both modes. The pause ends at the wrap from 1023 to 0, where the processor clock is low.
- R9: After a switch from stretch mode to ready mode, ready_o stays 1 until the next rising edge of the processor clock. It is then loaded as described in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Board oscillator clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Pause method: 0 holds the processor clock high, 1 drops the ready line |
| cpu_clk_o | output | 1 | Processor clock |
| ready_o | output | 1 | Processor ready line, registered on processor clock rising edges |
| halt_o | output | 1 | High while the pause window is active |

## Verification
The hardest situation to reach is a mode change in the middle of a pause window. The ready line must then keep its old value until the next processor clock rise, and it must not react to the window edge itself. The stimulus first waits for halt_o to rise, which takes 512 cycles after reset. It then flips the mode at several points: inside the window, just after the wrap, and during a low ready phase. A reset is also applied while ready_o is low. A cycle-accurate arithmetic model of the divider count predicts every output on every cycle.

// File: rtl/cpu_pause_pkg.sv
package cpu_pause_pkg;

    localparam int unsigned DEF_DIV_W   = 10;
    localparam int unsigned DEF_CLK_TAP = 3;

    typedef enum logic {
        PAUSE_BY_STRETCH = 1'b0,
        PAUSE_BY_READY   = 1'b1
    } pause_mode_e;

    // Decoded divider taps handed from the counter to the output stages.
    typedef struct packed {
        logic clk_level;      // current processor clock phase tap
        logic clk_rise_next;  // processor clock tap rises at the coming edge
        logic halt_now;       // window bit as currently held
        logic halt_next;      // window bit after the coming edge
    } div_taps_t;

    function automatic pause_mode_e decode_mode(input logic sel);
        return sel ? PAUSE_BY_READY : PAUSE_BY_STRETCH;
    endfunction

    function automatic logic tap_rises(input logic now_bit, input logic next_bit);
        return ~now_bit & next_bit;
    endfunction

endpackage

// File: rtl/cpu_pause_divider.sv
module cpu_pause_divider
    import cpu_pause_pkg::*;
#(
    parameter int unsigned DIV_W   = DEF_DIV_W,
    parameter int unsigned CLK_TAP = DEF_CLK_TAP
) (
    input  logic      clk_i,
    input  logic      rst_i,
    output div_taps_t taps_o
);
    localparam int unsigned HALT_TAP = DIV_W - 1;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_d;

    assign cnt_d = cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        taps_o.clk_level     = cnt_q[CLK_TAP];
        taps_o.clk_rise_next = tap_rises(cnt_q[CLK_TAP], cnt_d[CLK_TAP]) & ~rst_i;
        taps_o.halt_now      = cnt_q[HALT_TAP];
        taps_o.halt_next     = cnt_d[HALT_TAP];
    end
endmodule

// File: rtl/cpu_pause_clkshape.sv
module cpu_pause_clkshape
    import cpu_pause_pkg::*;
(
    input  pause_mode_e mode_i,
    input  div_taps_t   taps_i,
    output logic        cpu_clk_o
);
    always_comb begin
        cpu_clk_o = taps_i.clk_level;
        if (mode_i == PAUSE_BY_STRETCH && taps_i.halt_now) begin
            cpu_clk_o = 1'b1;
        end
    end
endmodule

// File: rtl/cpu_pause_ready.sv
module cpu_pause_ready
    import cpu_pause_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  pause_mode_e mode_i,
    input  div_taps_t   taps_i,
    output logic        ready_o
);
    logic ready_q;

    // Loaded only on oscillator edges that form a processor clock rising edge.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ready_q <= 1'b1;
        end else if (mode_i == PAUSE_BY_STRETCH) begin
            ready_q <= 1'b1;
        end else if (taps_i.clk_rise_next) begin
            ready_q <= ~taps_i.halt_next;
        end
    end

    assign ready_o = ready_q;
endmodule

// File: rtl/cpu_pause_gen.sv
module cpu_pause_gen
    import cpu_pause_pkg::*;
#(
    parameter int unsigned DIV_W   = DEF_DIV_W,
    parameter int unsigned CLK_TAP = DEF_CLK_TAP
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mode_i,
    output logic cpu_clk_o,
    output logic ready_o,
    output logic halt_o
);
    pause_mode_e mode;
    div_taps_t   taps;

    assign mode = decode_mode(mode_i);

    cpu_pause_divider #(
        .DIV_W  (DIV_W),
        .CLK_TAP(CLK_TAP)
    ) u_div (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .taps_o(taps)
    );

    cpu_pause_clkshape u_shape (
        .mode_i   (mode),
        .taps_i   (taps),
        .cpu_clk_o(cpu_clk_o)
    );

    cpu_pause_ready u_rdy (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .mode_i (mode),
        .taps_i (taps),
        .ready_o(ready_o)
    );

    assign halt_o = taps.halt_now;
endmodule

// File: rtl/cpu_pause_gen_chk.sv
module cpu_pause_gen_chk (
    input logic clk_i,
    input logic rst_i,
    input logic mode_i,
    input logic cpu_clk_o,
    input logic ready_o,
    input logic halt_o
);
    a_r1_reset_state: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (ready_o && !halt_o && !cpu_clk_o));

    a_r4_stretch_holds_high: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mode_i && halt_o) |-> cpu_clk_o);

    a_r5_ready_moves_on_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i && $past(mode_i) && !$past(rst_i) && !$stable(ready_o)) |-> $rose(cpu_clk_o));

    a_r6_ready_low_in_window: assert property (@(posedge clk_i) disable iff (rst_i)
        !ready_o |-> (halt_o || !cpu_clk_o));

    a_r7_stretch_ready_high: assert property (@(posedge clk_i) disable iff (rst_i)
        !mode_i |=> ready_o);

    a_r8_release_clock_low: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(halt_o) |-> !cpu_clk_o);
endmodule

bind cpu_pause_gen cpu_pause_gen_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .mode_i   (mode_i),
    .cpu_clk_o(cpu_clk_o),
    .ready_o  (ready_o),
    .halt_o   (halt_o)
);

// File: tb/sim_cpu_pause_gen.sv
`timescale 1ns/1ps
module sim_cpu_pause_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b0;
    logic cpu_clk, ready, halt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Arithmetic model of the requirements
    int  m_cnt = 0;
    bit  m_rdy = 1;
    bit  p_rdy, p_clk, p_mode_ok;

    always #5 clk = ~clk;

    cpu_pause_gen u0 (
        .clk_i(clk), .rst_i(rst), .mode_i(mode),
        .cpu_clk_o(cpu_clk), .ready_o(ready), .halt_o(halt)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            m_rdy = 1;
        end else begin
            int nxt;
            nxt = (m_cnt + 1) % 1024;
            if (!mode) m_rdy = 1;
            else if (nxt % 16 == 8) m_rdy = (nxt < 512);
            m_cnt = nxt;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (model count %0d)", tag, act, exp, m_cnt);
        end
    endtask

    function automatic bit exp_clk();
        bit b3;
        b3 = ((m_cnt >> 3) & 1) != 0;
        if (mode) return b3;
        return (m_cnt >= 512) ? 1'b1 : b3;
    endfunction

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(cpu_clk == exp_clk(), mode ? "R3 clock follows bit3" : "R4 stretch clock",
                cpu_clk, exp_clk());
            chk(ready == m_rdy, mode ? "R6 ready value" : "R7 ready held high", ready, m_rdy);
            chk(halt == (m_cnt >= 512), "R8 halt equals window bit", halt, m_cnt >= 512);
            if (p_mode_ok && mode && !rst && ready != p_rdy)
                chk(cpu_clk && !p_clk, "R5 ready change only on clock rise", cpu_clk, 1);
            p_mode_ok = mode && !rst;
            p_rdy = ready;
            p_clk = cpu_clk;
        end
    endtask

    task automatic wait_count(input int target);
        while (m_cnt != target) run(1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int hi;
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R1 reset ready", ready, 1);
        chk(halt == 1'b0, "R1 reset halt", halt, 0);
        chk(cpu_clk == 1'b0, "R1 reset clock", cpu_clk, 0);
        rst = 1'b0;
        p_mode_ok = 0;

        // R2: first rise of the window 512 cycles after release
        n = 0;
        while (!halt && n < 600) begin run(1); n++; end
        chk(n == 512, "R2 window start delay", n, 512);

        // R2: window occupies 512 of 1024 cycles (stretch mode)
        hi = 0;
        for (int i = 0; i < 1024; i++) begin
            run(1);
            if (halt) hi++;
        end
        chk(hi == 512, "R2 window duty", hi, 512);

        // R9: switch to ready mode inside the window
        wait_count(600);
        mode = 1'b1;
        run(1);
        chk(ready == 1'b1, "R9 ready holds after mode switch", ready, 1);
        wait_count(616);
        chk(ready == 1'b0, "R9 ready drops at next clock rise", ready, 0);
        run(2100);

        // R7: switch back to stretch during a low ready phase
        wait_count(700);
        mode = 1'b0;
        run(1);
        chk(ready == 1'b1, "R7 ready restored after stretch select", ready, 1);
        run(1100);

        // R9/R6: switch to ready just after the wrap
        wait_count(2);
        mode = 1'b1;
        run(1200);

        // R1: reset while ready is low
        wait_count(800);
        chk(ready == 1'b0, "R6 ready low inside window", ready, 0);
        rst = 1'b1;
        run(2);
        chk(ready == 1'b1 && halt == 1'b0 && cpu_clk == 1'b0, "R1 reset mid window",
            {ready, halt, cpu_clk}, 3'b100);
        rst = 1'b0;
        p_mode_ok = 0;
        run(1200);

        done = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule